// File: doc/BRIEF.md
# Processor Status Flags and Condition Decoder

This block turns a data word and the ALU carry out of its top bit into a set of five status flags. It holds them in a status register that loads only when the processor writes it. The flag set is aimed at multiplication loops. An odd flag steers shift-and-add multiplication. An equality flag on the two lowest data bits steers Booth recoding of signed operands. Non-zero, negative and overflow flags serve general conditional jumps.

From the stored flags and a 3-bit condition field taken from the instruction, the block produces two registered results. The first is a single-bit basic condition that the sequencer uses for conditional jumps. The second is a 2-bit variant index that picks one of up to four ways to execute an instruction. Both are updated every clock from the current condition field and the status value held at that edge. All outputs are registered and cleared by a synchronous active-high reset.

Top module: `cond_status_unit`

## Requirements
- R1: Flag bit 0 (non-zero) is stored as 1 when at least one bit of the data word is 1, and as 0 when the word is all zeros.
- R2: Flag bit 1 (odd) is stored equal to data bit 0.
- R3: Flag bit 2 (booth) is stored as 1 when data bit 0 and data bit 1 are equal, and as 0 when they differ.
- R4: Flag bit 3 (negative) is stored equal to the most significant data bit (bit 9 at the default width).
- R5: Flag bit 4 (overflow) is stored equal to the ALU carry input, whatever the data word is.
- R6: The flags load only on a clock edge where the write strobe is 1, and they appear on the flag output in the next cycle. On edges where the strobe is 0, the flag output keeps its value even when the data or the carry changes.
- R7: The basic condition is 1 when the condition field equals {negative, odd, non-zero}, with field bit 0 compared against non-zero, bit 1 against odd and bit 2 against negative.
- R8: The basic condition is 1 when the condition field is 000, whatever the stored flags are.
- R9: The variant index is chosen by condition bits 1:0 and is written here as {high, low}. 00 gives {non-zero, odd}, 01 gives {booth, odd}, 10 gives {negative, non-zero} and 11 gives {overflow, negative}.
- R10: The basic condition and the variant index are registered. Both reflect the condition field and the stored flags as they were at the previous clock edge, so a status write and a condition in the same cycle use the old flags.
- R11: A reset clears the flag output, the basic condition and the variant index to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 10 | Data bus word that the flags are derived from |
| alu_carry | input | 1 | ALU carry out of the top data bit |
| stat_wr | input | 1 | Status register write strobe |
| cond_sel | input | 3 | Condition field from the instruction |
| flags_o | output | 5 | Stored flags {overflow, negative, booth, odd, non-zero} |
| basic_o | output | 1 | Basic condition |
| variant_o | output | 2 | Alternative condition as a variant index |

## Verification
The bench drives every condition code against a range of stored flag patterns. These include all-ones with a carry, a lone top bit, alternating patterns, and zero data with a carry set. A decoder that swapped the comparison order would fail the equality cases, and one that forgot the 000 override would drop unconditional jumps. Writes with the strobe low must leave the flags unchanged; a register that loaded on every edge would follow the bus. When a write and a condition arrive in the same cycle, the result must come from the old flags. A decoder that used the incoming flags would answer one cycle early.

// File: rtl/cond_status_pkg.sv
package cond_status_pkg;
  localparam int FLAG_W = 5;
  localparam int COND_W = 3;
  localparam int VAR_W  = 2;

  typedef struct packed {
    logic ovf;
    logic neg;
    logic booth;
    logic odd;
    logic nz;
  } flags_t;
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import cond_status_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] data,
  input  logic              carry,
  output flags_t            flags
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    flags.nz    = |data;
    flags.odd   = data[0];
    flags.booth = ~(data[0] ^ data[1]);
    flags.neg   = data[MSB];
    flags.ovf   = carry;
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import cond_status_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   wr,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= d;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr) |=> $stable(q));
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr) |=> (q == $past(d)));
endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import cond_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond,
  input  flags_t            stat,
  output logic              basic,
  output logic [VAR_W-1:0]  variant
);
  logic [COND_W-1:0] cmp_vec;
  logic              basic_d;
  logic [VAR_W-1:0]  variant_d;

  assign cmp_vec = {stat.neg, stat.odd, stat.nz};

  always_comb begin
    basic_d = (cond == '0) || (cond == cmp_vec);
    unique case (cond[1:0])
      2'b00:   variant_d = {stat.nz,    stat.odd};
      2'b01:   variant_d = {stat.booth, stat.odd};
      2'b10:   variant_d = {stat.neg,   stat.nz};
      default: variant_d = {stat.ovf,   stat.neg};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      basic   <= 1'b0;
      variant <= '0;
    end else begin
      basic   <= basic_d;
      variant <= variant_d;
    end
  end

  a_r8_zero_field: assert property (@(posedge clk) disable iff (rst)
    (!rst && cond == '0) |=> basic);
  a_r7_mismatch: assert property (@(posedge clk) disable iff (rst)
    (!rst && cond != '0 && cond != {stat.neg, stat.odd, stat.nz}) |=> !basic);
  a_r9_sel_odd: assert property (@(posedge clk) disable iff (rst)
    (!rst && cond[0] == 1'b0 && cond[1] == 1'b0) |=> (variant[0] == $past(stat.odd)));
endmodule

// File: rtl/cond_status_unit.sv
module cond_status_unit
  import cond_status_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  input  logic              alu_carry,
  input  logic              stat_wr,
  input  logic [2:0]        cond_sel,
  output logic [4:0]        flags_o,
  output logic              basic_o,
  output logic [1:0]        variant_o
);
  flags_t flag_next;
  flags_t flag_q;

  flag_calc #(.DATA_W(DATA_W)) u_calc (
    .data  (data_in),
    .carry (alu_carry),
    .flags (flag_next)
  );

  status_reg u_stat (
    .clk (clk),
    .rst (rst),
    .wr  (stat_wr),
    .d   (flag_next),
    .q   (flag_q)
  );

  cond_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .cond    (cond_sel),
    .stat    (flag_q),
    .basic   (basic_o),
    .variant (variant_o)
  );

  assign flags_o = flag_q;

  a_r1_nonzero: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> (flags_o[0] == ($past(data_in) != '0)));
  a_r2_odd: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> (flags_o[1] == $past(data_in[0])));
  a_r3_booth: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> (flags_o[2] == ($past(data_in[0]) == $past(data_in[1]))));
  a_r4_negative: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> (flags_o[3] == $past(data_in[DATA_W-1])));
  a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
    (!rst && stat_wr) |=> (flags_o[4] == $past(alu_carry)));
endmodule

// File: tb/sim_cond_status_unit.sv
`timescale 1ns/1ps
module sim_cond_status_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] data_in;
  logic       alu_carry;
  logic       stat_wr;
  logic [2:0] cond_sel;
  logic [4:0] flags_o;
  logic       basic_o;
  logic [1:0] variant_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cond_status_unit u0 (
    .clk(clk), .rst(rst), .data_in(data_in), .alu_carry(alu_carry),
    .stat_wr(stat_wr), .cond_sel(cond_sel), .flags_o(flags_o),
    .basic_o(basic_o), .variant_o(variant_o)
  );

  // table entries: {carry, data}
  localparam logic [10:0] VEC [12] = '{
    {1'b0, 10'h000}, {1'b1, 10'h3FF}, {1'b0, 10'h001}, {1'b0, 10'h002},
    {1'b0, 10'h003}, {1'b0, 10'h200}, {1'b0, 10'h155}, {1'b1, 10'h2AA},
    {1'b1, 10'h1FE}, {1'b1, 10'h000}, {1'b0, 10'h201}, {1'b1, 10'h0F0}
  };

  function automatic logic [4:0] mflags(input logic [9:0] d, input logic c);
    return {c, d[9], (d[0] == d[1]), d[0], (d != 10'd0)};
  endfunction

  function automatic logic mbasic(input logic [2:0] cs, input logic [4:0] f);
    return (cs == 3'b000) || (cs == {f[3], f[1], f[0]});
  endfunction

  function automatic logic [1:0] mvar(input logic [2:0] cs, input logic [4:0] f);
    case (cs[1:0])
      2'b00:   return {f[0], f[1]};
      2'b01:   return {f[2], f[1]};
      2'b10:   return {f[3], f[0]};
      default: return {f[4], f[3]};
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] f;
    rst = 1'b1; data_in = '0; alu_carry = 1'b0; stat_wr = 1'b0; cond_sel = '0;
    tick; tick;
    chk("R11 flags after reset", {3'b0, flags_o}, 8'h00);
    chk("R11 basic after reset", {7'b0, basic_o}, 8'h00);
    chk("R11 variant after reset", {6'b0, variant_o}, 8'h00);
    #0 rst = 1'b0;

    // table walk: write, check flags R1-style per bit, then every condition code
    for (int i = 0; i < 12; i++) begin
      data_in = VEC[i][9:0]; alu_carry = VEC[i][10]; stat_wr = 1'b1;
      tick;
      stat_wr = 1'b0;
      f = mflags(VEC[i][9:0], VEC[i][10]);
      chk("R1 nonzero", {7'b0, flags_o[0]}, {7'b0, f[0]});
      chk("R2 odd", {7'b0, flags_o[1]}, {7'b0, f[1]});
      chk("R3 booth", {7'b0, flags_o[2]}, {7'b0, f[2]});
      chk("R4 negative", {7'b0, flags_o[3]}, {7'b0, f[3]});
      chk("R5 overflow", {7'b0, flags_o[4]}, {7'b0, f[4]});
      for (int c = 0; c < 8; c++) begin
        cond_sel = c[2:0];
        tick;
        chk((c == 0) ? "R8 zero field" : "R7 basic", {7'b0, basic_o},
            {7'b0, mbasic(c[2:0], f)});
        chk("R9 variant", {6'b0, variant_o}, {6'b0, mvar(c[2:0], f)});
      end
    end

    // R6: strobe low, bus changes, flags hold
    data_in = 10'h3FF; alu_carry = 1'b1; stat_wr = 1'b1;
    tick;
    data_in = 10'h000; alu_carry = 1'b0; stat_wr = 1'b0;
    tick; tick;
    chk("R6 hold without strobe", {3'b0, flags_o}, {3'b0, 5'b11111});

    // R10: write and condition in same cycle use old flags
    // stored = 11111 so {neg,odd,nz}=111; new data 0 would give 000
    cond_sel = 3'b111; data_in = 10'h000; alu_carry = 1'b0; stat_wr = 1'b1;
    tick;
    stat_wr = 1'b0;
    chk("R10 basic uses old flags", {7'b0, basic_o}, 8'h01);
    chk("R10 new flags stored", {3'b0, flags_o}, {3'b0, mflags(10'h000, 1'b0)});
    tick;
    chk("R10 basic follows new flags", {7'b0, basic_o}, 8'h00);

    // R5: overflow independent of data (zero data, carry set)
    data_in = 10'h000; alu_carry = 1'b1; stat_wr = 1'b1; cond_sel = 3'b011;
    tick;
    stat_wr = 1'b0;
    tick;
    chk("R5 overflow with zero data", {7'b0, flags_o[4]}, 8'h01);
    chk("R9 sel 11 overflow high", {6'b0, variant_o}, 8'h02);

    // R11: mid-run reset
    data_in = 10'h3FF; stat_wr = 1'b1; cond_sel = 3'b000;
    tick;
    stat_wr = 1'b0; rst = 1'b1;
    tick;
    rst = 1'b0;
    chk("R11 mid-run reset flags", {3'b0, flags_o}, 8'h00);
    chk("R11 mid-run reset basic", {7'b0, basic_o}, 8'h00);
    chk("R11 mid-run reset variant", {6'b0, variant_o}, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule